// File: doc/BRIEF.md
# Configurable PLD Macrocell

This block is one output cell of a programmable-logic array, modelled in synthesizable logic. It takes a vector of product-term results that an upstream AND array has already evaluated, combines them into one sum term and passes that term either straight through or through a storage element. The storage element works as a D-type or a T-type flip-flop. A static configuration word selects the path, the polarity, the flip-flop type and which of four shared clock lines the register follows.

The four clock lines are sampled by one fast system clock. A register update happens when a rising edge is detected on the selected line, so the whole cell stays in a single clock domain. Two shared product terms, one for clear and one for set, force the register at the next system clock edge. They take priority over any clock update, and the clear term wins over the set term. The cell drives two outputs: one for the pin side and one that feeds back into the array.

Top module: `pld_macrocell`

## Requirements
- R1: The sum term is the OR of all NUM_PT product-term inputs. In combinational mode (`cfg_registered`=0), `mc_out` equals that sum with no clock latency.
- R2: With `cfg_invert`=1, `mc_out` is the complement of what it shows with `cfg_invert`=0. In combinational mode it is the inverted sum. In registered mode it is the inverted register value.
- R3: In registered mode `mc_fb` carries the register value before the polarity stage. In combinational mode `mc_fb` equals `mc_out`, which is the polarity-adjusted sum.
- R4: In D mode (`cfg_toggle`=0), a detected rising edge on the selected clock line loads the sum term into the register.
- R5: In T mode (`cfg_toggle`=1), a detected rising edge inverts the register when the sum term is 1 and leaves it unchanged when the sum term is 0.
- R6: `cfg_clk_sel` (binary 0..3) picks which `gclk_in` bit clocks the register. Edges on the other three lines leave the register unchanged.
- R7: Only low-to-high transitions update the register, and a falling edge has no effect. A line driven high before system clock edge k updates the register at edge k+2, the third edge that sees it high: two synchronizer stages plus one edge-detect stage.
- R8: `ar_pt`=1 clears the register at the next system clock edge. This overrides a clock update that falls in the same cycle.
- R9: `ap_pt`=1 sets the register at the next system clock edge and overrides a same-cycle clock update. When `ar_pt` and `ap_pt` are both 1, the register clears.
- R10: `rst_n` low at a system clock edge clears the register and the edge detectors. The register then reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pt_in | input | NUM_PT (16) | Evaluated product-term results |
| gclk_in | input | 4 | Shared global clock lines |
| ar_pt | input | 1 | Shared clear product term |
| ap_pt | input | 1 | Shared set product term |
| cfg_registered | input | 1 | 1 selects the register path, 0 the combinational path |
| cfg_invert | input | 1 | 1 inverts the output polarity |
| cfg_toggle | input | 1 | 1 selects T-type, 0 D-type |
| cfg_clk_sel | input | 2 | Index of the clock line for the register |
| mc_out | output | 1 | Pin-side output |
| mc_fb | output | 1 | Feedback output to the array |

## Verification
Two of the cell's functions can land in the same system cycle: a clock update from a detected edge on the selected line, and a forced clear or set from the shared product terms. The bench provokes this by raising a clock line and asserting `ar_pt` or `ap_pt` in exactly the cycle the detected edge is due. It picks the sum so that the loaded value would differ from the forced one. The force is judged correct when the register holds the forced value afterwards and the consumed edge leaves no later update. The same method checks clear against set when both are asserted together.

// File: rtl/pld_mc_pkg.sv
// Package: shared constants and the configuration record of the macrocell.
// Assumes: exactly four global clock lines feed every macrocell.
package pld_mc_pkg;
    localparam int GCLK_COUNT = 4;
    localparam int GCLK_SEL_W = $clog2(GCLK_COUNT);

    // Static configuration of one macrocell.
    typedef struct packed {
        logic                  registered;
        logic                  invert;
        logic                  toggle;
        logic [GCLK_SEL_W-1:0] clk_sel;
    } mc_cfg_t;
endpackage

// File: rtl/mc_sum_polarity.sv
// Module: ORs the product-term vector into a sum term and applies polarity.
// Assumes: product terms arrive already evaluated; purely combinational.
module mc_sum_polarity #(
    parameter int NUM_PT = 16
) (
    input  logic [NUM_PT-1:0] pt,
    input  logic              invert,
    output logic              sum_raw,
    output logic              sum_pol
);
    // Purpose: sum term and its polarity-adjusted copy.
    always_comb begin
        sum_raw = |pt;
        sum_pol = sum_raw ^ invert;
    end

    // R1/R2: an all-zero vector gives the polarity bit itself.
    always_comb begin
        if (pt == '0) assert_zero_sum_R1: assert (sum_pol == invert);
    end
endmodule

// File: rtl/mc_clk_select.sv
// Module: synchronizes each global clock line to the system clock, detects
// rising edges per line and forwards the edge pulse of the selected line.
// Assumes: clock lines are slow relative to clk (each level lasts >= 2 cycles).
module mc_clk_select #(
    parameter int NUM_CLK     = 4,
    parameter int SYNC_STAGES = 2,
    localparam int SEL_W      = $clog2(NUM_CLK)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_CLK-1:0] gclk,
    input  logic [SEL_W-1:0]   sel,
    output logic               upd
);
    logic [NUM_CLK-1:0] synced;
    logic [NUM_CLK-1:0] prev;
    logic [NUM_CLK-1:0] rise;

    for (genvar g = 0; g < NUM_CLK; g++) begin : g_line
        logic [SYNC_STAGES-1:0] chain;
        // Purpose: multi-stage synchronizer for one clock line.
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[SYNC_STAGES-2:0], gclk[g]};
        end
        assign synced[g] = chain[SYNC_STAGES-1];
    end

    // Purpose: remember last synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= '0;
        else        prev <= synced;
    end

    // Purpose: rising-edge pulse per line and selection of one line.
    always_comb begin
        rise = synced & ~prev;
        upd  = rise[sel];
    end

    // R7: an edge pulse on any line lasts exactly one cycle.
    assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rise != '0) |=> ((rise & $past(rise)) == '0));
endmodule

// File: rtl/mc_storage.sv
// Module: the macrocell flip-flop with D/T behaviour and forced clear/set.
// Assumes: clear and set are sampled by the system clock; clear has priority.
module mc_storage (
    input  logic clk,
    input  logic rst_n,
    input  logic upd,
    input  logic d,
    input  logic toggle,
    input  logic ar,
    input  logic ap,
    output logic q
);
    // Purpose: next register state with clear > set > clocked update.
    always_ff @(posedge clk) begin
        if (!rst_n)   q <= 1'b0;
        else if (ar)  q <= 1'b0;
        else if (ap)  q <= 1'b1;
        else if (upd) q <= toggle ? (q ^ d) : d;
    end

    assert_clear_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ar |=> !q);
    assert_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ap && !ar) |=> q);
    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ar && !ap && !upd) |=> $stable(q));
    assert_toggle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ar && !ap && upd && toggle && d) |=> (q != $past(q)));
    assert_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ar && !ap && upd && !toggle) |=> (q == $past(d)));
endmodule

// File: rtl/pld_macrocell.sv
// Module: top of the configurable macrocell. Combines the sum/polarity
// stage, the clock-line selector and the storage element, and muxes the
// pin-side and feedback outputs according to the configuration.
// Assumes: configuration is static while clock edges are in flight.
module pld_macrocell
    import pld_mc_pkg::*;
#(
    parameter int NUM_PT      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_PT-1:0]     pt_in,
    input  logic [GCLK_COUNT-1:0] gclk_in,
    input  logic                  ar_pt,
    input  logic                  ap_pt,
    input  logic                  cfg_registered,
    input  logic                  cfg_invert,
    input  logic                  cfg_toggle,
    input  logic [GCLK_SEL_W-1:0] cfg_clk_sel,
    output logic                  mc_out,
    output logic                  mc_fb
);
    mc_cfg_t cfg;
    logic    sum_raw;
    logic    sum_pol;
    logic    upd;
    logic    q;

    // Purpose: gather configuration pins into one record.
    always_comb begin
        cfg.registered = cfg_registered;
        cfg.invert     = cfg_invert;
        cfg.toggle     = cfg_toggle;
        cfg.clk_sel    = cfg_clk_sel;
    end

    mc_sum_polarity #(.NUM_PT(NUM_PT)) u_sum (
        .pt      (pt_in),
        .invert  (cfg.invert),
        .sum_raw (sum_raw),
        .sum_pol (sum_pol)
    );

    mc_clk_select #(.NUM_CLK(GCLK_COUNT), .SYNC_STAGES(SYNC_STAGES)) u_clk (
        .clk   (clk),
        .rst_n (rst_n),
        .gclk  (gclk_in),
        .sel   (cfg.clk_sel),
        .upd   (upd)
    );

    mc_storage u_reg (
        .clk    (clk),
        .rst_n  (rst_n),
        .upd    (upd),
        .d      (sum_raw),
        .toggle (cfg.toggle),
        .ar     (ar_pt),
        .ap     (ap_pt),
        .q      (q)
    );

    // Purpose: output and feedback selection per configuration.
    always_comb begin
        if (cfg.registered) begin
            mc_out = q ^ cfg.invert;
            mc_fb  = q;
        end else begin
            mc_out = sum_pol;
            mc_fb  = sum_pol;
        end
    end

    // R3: feedback relation to the pin output in each mode.
    assert_fb_comb_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_registered |-> (mc_fb == mc_out));
    assert_fb_reg_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_registered |-> (mc_out == (mc_fb ^ cfg_invert)));
    // R10: after a reset cycle the register reads zero.
    assert_reset_R10: assert property (@(posedge clk)
        !rst_n |=> (!cfg_registered || mc_fb == 1'b0));
endmodule

// File: tb/pld_macrocell_tb.sv
`timescale 1ns/1ps
module pld_macrocell_tb_top;
    localparam int NUM_PT = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NUM_PT-1:0] pt_in = '0;
    logic [3:0]        gclk_in = '0;
    logic              ar_pt = 1'b0;
    logic              ap_pt = 1'b0;
    logic              cfg_registered = 1'b1;
    logic              cfg_invert = 1'b0;
    logic              cfg_toggle = 1'b0;
    logic [1:0]        cfg_clk_sel = '0;
    logic              mc_out;
    logic              mc_fb;

    int checks = 0;
    int fails  = 0;
    logic model_q = 1'b0;

    always #4 clk = ~clk;

    pld_macrocell #(.NUM_PT(NUM_PT)) dut_i (
        .clk(clk), .rst_n(rst_n), .pt_in(pt_in), .gclk_in(gclk_in),
        .ar_pt(ar_pt), .ap_pt(ap_pt), .cfg_registered(cfg_registered),
        .cfg_invert(cfg_invert), .cfg_toggle(cfg_toggle),
        .cfg_clk_sel(cfg_clk_sel), .mc_out(mc_out), .mc_fb(mc_fb)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // Raise one line, keep it high, then drop it; checks around each phase.
    task automatic pulse_line(input int line, input string req, input logic exp_q);
        @(negedge clk) gclk_in[line] = 1'b1;
        repeat (4) @(negedge clk);
        check(req, mc_fb, exp_q);
        gclk_in[line] = 1'b0;
        repeat (4) @(negedge clk);
        check("R7 falling edge ignored", mc_fb, exp_q);
    endtask

    task automatic force_pulse(input logic a, input logic p);
        @(negedge clk);
        ar_pt = a; ap_pt = p;
        @(negedge clk);
        ar_pt = 1'b0; ap_pt = 1'b0;
    endtask

    initial begin
        #(200000 * 8);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 reset fb", mc_fb, 1'b0);
        check("R10 reset out", mc_out, 1'b0);

        // Combinational sweep: R1 R2 R3
        cfg_registered = 1'b0;
        for (int inv = 0; inv < 2; inv++) begin
            cfg_invert = inv[0];
            for (int k = 0; k < 60; k++) begin
                logic [NUM_PT-1:0] p;
                if (k == 0)        p = '0;
                else if (k == 1)   p = '1;
                else if (k < 18)   p = NUM_PT'(1) << (k - 2);
                else               p = NUM_PT'((k * 40503) >> (k % 7));
                pt_in = p;
                #1;
                check("R1 R2 comb out", mc_out, (|p) ^ inv[0]);
                check("R3 comb fb", mc_fb, mc_out);
            end
        end

        // Registered sweep: R4 R5 R6 R2 R3
        cfg_registered = 1'b1;
        for (int tg = 0; tg < 2; tg++) begin
            for (int sel = 0; sel < 4; sel++) begin
                for (int inv = 0; inv < 2; inv++) begin
                    for (int dv = 0; dv < 2; dv++) begin
                        cfg_toggle = tg[0];
                        cfg_clk_sel = sel[1:0];
                        cfg_invert = inv[0];
                        pt_in = dv[0] ? (NUM_PT'(1) << (sel * 3 + dv)) : '0;
                        pulse_line((sel + 1) % 4, "R6 other line ignored", model_q);
                        model_q = tg[0] ? (model_q ^ dv[0]) : dv[0];
                        pulse_line(sel, tg[0] ? "R5 toggle" : "R4 load", model_q);
                        check("R2 R3 reg out polarity", mc_out, model_q ^ inv[0]);
                    end
                end
            end
        end

        // Latency R7: D mode, load complement of current value on line 2
        cfg_toggle = 1'b0; cfg_clk_sel = 2'd2; cfg_invert = 1'b0;
        pt_in = model_q ? '0 : NUM_PT'(1);
        @(negedge clk) gclk_in[2] = 1'b1;
        repeat (2) @(negedge clk);
        check("R7 no update after two edges", mc_fb, model_q);
        @(negedge clk);
        model_q = ~model_q;
        check("R7 update at third edge", mc_fb, model_q);
        repeat (2) @(negedge clk) gclk_in[2] = 1'b0;
        repeat (3) @(negedge clk);

        // Forced set, clear, both: R8 R9
        force_pulse(1'b0, 1'b1);
        check("R9 set", mc_fb, 1'b1);
        force_pulse(1'b1, 1'b0);
        check("R8 clear", mc_fb, 1'b0);
        force_pulse(1'b0, 1'b1);
        force_pulse(1'b1, 1'b1);
        check("R9 clear wins over set", mc_fb, 1'b0);

        // Collision: clear in the update cycle, D=1, Q=1 beforehand (R8)
        force_pulse(1'b0, 1'b1);
        pt_in = NUM_PT'(1);
        @(negedge clk) gclk_in[2] = 1'b1;
        repeat (2) @(negedge clk);
        ar_pt = 1'b1;
        @(negedge clk) ar_pt = 1'b0;
        check("R8 clear beats clock update", mc_fb, 1'b0);
        repeat (3) @(negedge clk);
        check("R8 no late update", mc_fb, 1'b0);
        gclk_in[2] = 1'b0;
        repeat (4) @(negedge clk);

        // Collision: set in the update cycle, D=0 (R9)
        pt_in = '0;
        @(negedge clk) gclk_in[2] = 1'b1;
        repeat (2) @(negedge clk);
        ap_pt = 1'b1;
        @(negedge clk) ap_pt = 1'b0;
        check("R9 set beats clock update", mc_fb, 1'b1);
        repeat (3) @(negedge clk);
        check("R9 no late update", mc_fb, 1'b1);
        gclk_in[2] = 1'b0;
        repeat (4) @(negedge clk);

        // Reset mid-run clears register (R10)
        rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        check("R10 reset clears", mc_fb, 1'b0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule